// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block sits next to a small processor core. It decides when an interrupt handler is entered and where it starts, and it holds the code segment and instruction pointer that the core fetches from after reset. It watches two request lines. The first is a nonmaskable line, which is edge-sensitive and always uses interrupt number 2. The second is a maskable line, which is level-sensitive and is gated by an interrupt-enable flag.

A request is only taken when the core reports an instruction boundary. A maskable request first runs one interrupt acknowledge bus cycle, which returns an 8-bit interrupt number. The vector for that number occupies four bytes at byte address number×4. The block reads those bytes one at a time and then loads the new segment and pointer into the core in a single cycle.

The bus unit carries out each transfer request. It holds each request until it pulses a done strobe, so it may insert any number of wait cycles. The core drives two pulse inputs that set and clear the enable flag. The block also provides the physical fetch address, formed from the segment and the pointer.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the code segment output is FFFFh, the pointer output is 0000h, the physical fetch address is FFFF0h, the enable flag is 0, and busy and bus request are both 0.
- R2: A nonmaskable entry runs no acknowledge cycle (bus_inta stays 0). It reads byte addresses 8, 9, 10 and 11 in that order, and loads pointer = {byte9, byte8} and segment = {byte11, byte10}.
- R3: A maskable request while the enable flag is 0 is not accepted: busy and bus_req stay 0 and no bus cycle occurs, even across instruction boundaries.
- R4: An accepted maskable request runs exactly one bus cycle with bus_inta=1 and bus_addr=0, whose data byte is the interrupt number N. It then reads addresses 4N, 4N+1, 4N+2 and 4N+3 with bus_inta=0, and loads pointer = {byte(4N+1), byte(4N)} and segment = {byte(4N+3), byte(4N+2)}.
- R5: No request is accepted in a cycle where instr_done is 0, and instr_done has no effect while busy is 1.
- R6: When both requests are pending at the same boundary, the nonmaskable entry is taken. The maskable request is served at a later boundary once the enable flag is set again.
- R7: A nonmaskable input held high produces exactly one entry. A new entry needs a low-to-high transition.
- R8: ie_set sets the enable flag and ie_clr clears it, one cycle later. Acceptance of any entry clears the flag in the same cycle that busy rises.
- R9: busy rises in the cycle after acceptance and falls in the cycle in which pc_load pulses high for one cycle together with the new segment and pointer.
- R10: pc_phys always equals segment×16 + pointer, truncated to 20 bits.
- R11: While bus_req is high and bus_done has not been seen, bus_req, bus_addr and bus_inta are held unchanged for any number of wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_in | input | 1 | Nonmaskable request, rising-edge sensitive |
| irq_in | input | 1 | Maskable request, level sensitive |
| instr_done | input | 1 | Core is at an instruction boundary |
| ie_set | input | 1 | Set the interrupt-enable flag |
| ie_clr | input | 1 | Clear the interrupt-enable flag |
| bus_req | output | 1 | Transfer request to the bus unit |
| bus_inta | output | 1 | Request is an interrupt acknowledge cycle |
| bus_addr | output | 20 | Byte address of a vector read |
| bus_done | input | 1 | One-cycle strobe: transfer complete, data valid |
| bus_data | input | 8 | Byte returned by the bus unit |
| busy | output | 1 | An entry is in progress |
| ie_flag | output | 1 | Interrupt-enable flag |
| pc_load | output | 1 | One-cycle strobe: new segment and pointer |
| cs_out | output | 16 | Code segment |
| ip_out | output | 16 | Instruction pointer |
| pc_phys | output | 20 | Physical fetch address |

## Verification
The hardest situation to reach is both requests pending at the same instruction boundary while the enable flag is set. The bench produces it by raising the maskable line, pulsing the nonmaskable line one cycle earlier, and only then signalling the boundary. The bench then confirms that the maskable request waits until the flag is set again. A second hard case is a nonmaskable line held high across several boundaries; it is driven that way to show that only one entry results. A sweep of all 256 acknowledge numbers with varying wait cycles covers the vector address and byte-ordering arithmetic, including segment values whose physical address wraps past 20 bits.

// File: rtl/ies_pkg.sv
package ies_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACK  = 2'd1,
        ST_READ = 2'd2
    } seq_state_e;
endpackage

// File: rtl/ies_nmi_latch.sv
module ies_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_in,
    input  logic take,
    output logic pend
);
    typedef struct packed {
        logic prev;
        logic pend;
    } latch_t;

    latch_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.prev = nmi_in;
        // a new edge wins over a clear in the same cycle
        r_d.pend = (r_q.pend && !take) || (nmi_in && !r_q.prev);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pend = r_q.pend;

    // a level held high across edges never re-arms the pending request
    p_held_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_in && r_q.prev && (!r_q.pend || take)) |=> !r_q.pend);
endmodule

// File: rtl/ies_arbiter.sv
module ies_arbiter (
    input  logic nmi_pend,
    input  logic irq_req,
    input  logic ie,
    input  logic boundary,
    input  logic idle,
    output logic take_nmi,
    output logic take_irq
);
    logic window;

    always_comb begin
        window   = boundary && idle;
        take_nmi = window && nmi_pend;
        take_irq = window && !nmi_pend && irq_req && ie;
    end
endmodule

// File: rtl/ies_entry_fsm.sv
module ies_entry_fsm
    import ies_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int DATA_W   = 8,
    parameter int NMI_NUM  = 2,
    parameter int RESET_CS = 'hFFFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take_nmi,
    input  logic                take_irq,
    input  logic                ie_set,
    input  logic                ie_clr,
    input  logic                bus_done,
    input  logic [DATA_W-1:0]   bus_data,
    output logic                bus_req,
    output logic                bus_inta,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic                busy,
    output logic                ie_flag,
    output logic                pc_load,
    output logic [2*DATA_W-1:0] cs_out,
    output logic [2*DATA_W-1:0] ip_out
);
    localparam int SEG_W   = 2 * DATA_W;
    localparam int ACC_W   = 3 * DATA_W;
    localparam int LAST_IX = 3;

    typedef struct packed {
        seq_state_e        st;
        logic [1:0]        idx;
        logic [DATA_W-1:0] num;
        logic [ACC_W-1:0]  acc;
        logic              ie;
        logic [SEG_W-1:0]  cs;
        logic [SEG_W-1:0]  ip;
        logic              load;
    } fsm_t;

    fsm_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.load = 1'b0;
        if (ie_set) r_d.ie = 1'b1;
        if (ie_clr) r_d.ie = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (take_nmi) begin
                    r_d.st  = ST_READ;
                    r_d.num = DATA_W'(NMI_NUM);
                    r_d.idx = '0;
                    r_d.ie  = 1'b0;
                end else if (take_irq) begin
                    r_d.st  = ST_ACK;
                    r_d.num = '0;
                    r_d.idx = '0;
                    r_d.ie  = 1'b0;
                end
            end
            ST_ACK: begin
                if (bus_done) begin
                    r_d.num = bus_data;
                    r_d.st  = ST_READ;
                end
            end
            ST_READ: begin
                if (bus_done) begin
                    if (int'(r_q.idx) == LAST_IX) begin
                        r_d.ip   = r_q.acc[SEG_W-1:0];
                        r_d.cs   = {bus_data, r_q.acc[ACC_W-1:SEG_W]};
                        r_d.load = 1'b1;
                        r_d.st   = ST_IDLE;
                    end else begin
                        r_d.acc[int'(r_q.idx)*DATA_W +: DATA_W] = bus_data;
                        r_d.idx = r_q.idx + 2'd1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
            r_q.cs <= SEG_W'(RESET_CS);
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_req  = (r_q.st != ST_IDLE);
    assign bus_inta = (r_q.st == ST_ACK);
    assign bus_addr = (r_q.st == ST_READ) ? ADDR_W'({r_q.num, r_q.idx}) : '0;
    assign busy     = (r_q.st != ST_IDLE);
    assign ie_flag  = r_q.ie;
    assign pc_load  = r_q.load;
    assign cs_out   = r_q.cs;
    assign ip_out   = r_q.ip;

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_done) |=> (bus_req && $stable(bus_addr) && $stable(bus_inta)));

    p_nmi_no_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_nmi |=> (bus_req && !bus_inta && bus_addr == ADDR_W'(NMI_NUM * 4)));

    p_ack_then_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_inta && bus_done) |=> (bus_req && !bus_inta && bus_addr[1:0] == 2'b00));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 8,
    parameter int NMI_NUM   = 2,
    parameter int RESET_CS  = 'hFFFF,
    parameter int SEG_SHIFT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                nmi_in,
    input  logic                irq_in,
    input  logic                instr_done,
    input  logic                ie_set,
    input  logic                ie_clr,
    output logic                bus_req,
    output logic                bus_inta,
    output logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_done,
    input  logic [DATA_W-1:0]   bus_data,
    output logic                busy,
    output logic                ie_flag,
    output logic                pc_load,
    output logic [2*DATA_W-1:0] cs_out,
    output logic [2*DATA_W-1:0] ip_out,
    output logic [ADDR_W-1:0]   pc_phys
);
    logic nmi_pend;
    logic take_nmi;
    logic take_irq;

    ies_nmi_latch u_nmi (
        .clk    (clk),
        .rst_n  (rst_n),
        .nmi_in (nmi_in),
        .take   (take_nmi),
        .pend   (nmi_pend)
    );

    ies_arbiter u_arb (
        .nmi_pend (nmi_pend),
        .irq_req  (irq_in),
        .ie       (ie_flag),
        .boundary (instr_done),
        .idle     (!busy),
        .take_nmi (take_nmi),
        .take_irq (take_irq)
    );

    ies_entry_fsm #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .NMI_NUM  (NMI_NUM),
        .RESET_CS (RESET_CS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_nmi (take_nmi),
        .take_irq (take_irq),
        .ie_set   (ie_set),
        .ie_clr   (ie_clr),
        .bus_done (bus_done),
        .bus_data (bus_data),
        .bus_req  (bus_req),
        .bus_inta (bus_inta),
        .bus_addr (bus_addr),
        .busy     (busy),
        .ie_flag  (ie_flag),
        .pc_load  (pc_load),
        .cs_out   (cs_out),
        .ip_out   (ip_out)
    );

    assign pc_phys = ADDR_W'({cs_out, {SEG_SHIFT{1'b0}}}) + ADDR_W'(ip_out);

    p_ie_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !ie_flag);

    p_accept_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(instr_done));

    p_load_ends_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> (!busy && $past(busy)));
endmodule

// File: tb/irq_entry_seq_bench.sv
module irq_entry_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_in = 1'b0, irq_in = 1'b0, instr_done = 1'b0;
    logic        ie_set = 1'b0, ie_clr = 1'b0;
    logic        bus_req, bus_inta, bus_done;
    logic [19:0] bus_addr, pc_phys;
    logic [7:0]  bus_data;
    logic        busy, ie_flag, pc_load;
    logic [15:0] cs_out, ip_out;

    int checks = 0;
    int fails = 0;
    int inta_cnt = 0;
    int rd_cnt = 0;
    int stab_err = 0;
    int wait_cfg = 0;
    logic [7:0]  ack_num = 8'h00;
    logic [19:0] rd_log [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_entry_seq u_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .irq_in(irq_in),
        .instr_done(instr_done), .ie_set(ie_set), .ie_clr(ie_clr),
        .bus_req(bus_req), .bus_inta(bus_inta), .bus_addr(bus_addr),
        .bus_done(bus_done), .bus_data(bus_data), .busy(busy),
        .ie_flag(ie_flag), .pc_load(pc_load), .cs_out(cs_out),
        .ip_out(ip_out), .pc_phys(pc_phys)
    );

    function automatic logic [7:0] mem_byte(input logic [19:0] a);
        logic [7:0] m;
        m = 8'(a[7:0] * 8'd37);
        m = m ^ {a[9:8], 6'b0};
        return m + 8'h5B;
    endfunction

    // bus unit model with configurable wait cycles
    initial begin
        int cnt;
        logic [19:0] hold_addr;
        logic        hold_inta;
        cnt = 0;
        hold_addr = '0;
        hold_inta = 1'b0;
        bus_done = 1'b0;
        bus_data = '0;
        forever begin
            @(negedge clk);
            if (bus_done) begin
                bus_done = 1'b0;
                cnt = 0;
            end else if (rst_n && bus_req) begin
                if (cnt == 0) begin
                    hold_addr = bus_addr;
                    hold_inta = bus_inta;
                end else if (bus_addr != hold_addr || bus_inta != hold_inta) begin
                    stab_err++;
                end
                if (cnt >= wait_cfg) begin
                    bus_done = 1'b1;
                    if (bus_inta) begin
                        bus_data = ack_num;
                        inta_cnt++;
                    end else begin
                        bus_data = mem_byte(bus_addr);
                        rd_log[rd_cnt % 4] = bus_addr;
                        rd_cnt++;
                    end
                end else begin
                    cnt++;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_done();
        instr_done = 1'b1;
        @(negedge clk);
        instr_done = 1'b0;
    endtask

    task automatic pulse_ie(input bit set);
        if (set) ie_set = 1'b1; else ie_clr = 1'b1;
        @(negedge clk);
        ie_set = 1'b0;
        ie_clr = 1'b0;
    endtask

    task automatic pulse_nmi();
        nmi_in = 1'b1;
        @(negedge clk);
        nmi_in = 1'b0;
    endtask

    task automatic run_entry(input bit is_nmi, input logic [7:0] num, input string tag);
        int b_inta = inta_cnt;
        int b_rd = rd_cnt;
        int n = 0;
        logic [19:0] base;
        logic [15:0] ecs, eip;
        logic [19:0] ephys;
        pulse_done();
        chk("R9 busy after accept", 32'(busy), 32'd1);
        chk("R8 flag cleared on accept", 32'(ie_flag), 32'd0);
        while (!pc_load && n < 400) begin
            @(negedge clk);
            n++;
        end
        base = {10'b0, num, 2'b00};
        eip = {mem_byte(base + 20'd1), mem_byte(base)};
        ecs = {mem_byte(base + 20'd3), mem_byte(base + 20'd2)};
        ephys = 20'({ecs, 4'b0}) + 20'(eip);
        chk({tag, " load strobe"}, 32'(pc_load), 32'd1);
        chk({tag, " segment"}, 32'(cs_out), 32'(ecs));
        chk({tag, " pointer"}, 32'(ip_out), 32'(eip));
        chk("R10 physical address", 32'(pc_phys), 32'(ephys));
        chk("R9 busy low at load", 32'(busy), 32'd0);
        chk({tag, " ack cycles"}, 32'(inta_cnt - b_inta), is_nmi ? 32'd0 : 32'd1);
        chk({tag, " read count"}, 32'(rd_cnt - b_rd), 32'd4);
        chk({tag, " first read addr"}, 32'(rd_log[0]), 32'(base));
        chk({tag, " last read addr"}, 32'(rd_log[3]), 32'(base + 20'd3));
        chk("R11 request held", 32'(stab_err), 32'd0);
        @(negedge clk);
        chk("R9 load is one cycle", 32'(pc_load), 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 segment", 32'(cs_out), 32'h0000_FFFF);
        chk("R1 pointer", 32'(ip_out), 32'd0);
        chk("R1 physical", 32'(pc_phys), 32'h000F_FFF0);
        chk("R1 flag", 32'(ie_flag), 32'd0);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 bus request", 32'(bus_req), 32'd0);

        // R8 flag control
        pulse_ie(1'b1);
        chk("R8 set", 32'(ie_flag), 32'd1);
        pulse_ie(1'b0);
        chk("R8 clear", 32'(ie_flag), 32'd0);

        // R3 masked request ignored
        irq_in = 1'b1;
        for (int i = 0; i < 3; i++) begin
            pulse_done();
            chk("R3 busy", 32'(busy), 32'd0);
            chk("R3 bus request", 32'(bus_req), 32'd0);
        end
        chk("R3 no ack cycle", 32'(inta_cnt), 32'd0);

        // R5 no boundary, no acceptance
        pulse_ie(1'b1);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R5 busy without boundary", 32'(busy), 32'd0);
        end
        ack_num = 8'h3C;
        wait_cfg = 2;
        run_entry(1'b0, 8'h3C, "R4");
        irq_in = 1'b0;

        // R5 boundary during an entry has no effect
        pulse_ie(1'b1);
        irq_in = 1'b1;
        ack_num = 8'h11;
        wait_cfg = 3;
        pulse_done();
        pulse_done();
        pulse_done();
        while (!pc_load) @(negedge clk);
        chk("R5 single ack for boundaries while busy", 32'(inta_cnt), 32'd2);
        @(negedge clk);
        irq_in = 1'b0;
        wait_cfg = 0;

        // R2 nonmaskable entry
        pulse_nmi();
        run_entry(1'b1, 8'd2, "R2");

        // R6 both pending at one boundary
        pulse_ie(1'b1);
        irq_in = 1'b1;
        ack_num = 8'h77;
        pulse_nmi();
        run_entry(1'b1, 8'd2, "R6");
        pulse_done();
        chk("R6 masked waits for flag", 32'(busy), 32'd0);
        pulse_ie(1'b1);
        run_entry(1'b0, 8'h77, "R6");
        irq_in = 1'b0;

        // R7 held level gives one entry
        nmi_in = 1'b1;
        @(negedge clk);
        run_entry(1'b1, 8'd2, "R7");
        for (int i = 0; i < 3; i++) begin
            pulse_done();
            chk("R7 no second entry", 32'(busy), 32'd0);
        end
        nmi_in = 1'b0;
        @(negedge clk);

        // sweep of every acknowledge number with varied wait cycles
        for (int n = 0; n < 256; n++) begin
            wait_cfg = n % 3;
            ack_num = 8'(n);
            pulse_ie(1'b1);
            irq_in = 1'b1;
            run_entry(1'b0, 8'(n), "R4");
            irq_in = 1'b0;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule